// File: doc/BRIEF.md
# Ring Token Queue Slot Allocator

This block is one station on a ring of processing kernels that all append messages to one shared queue in memory. A token register passes from station to station, one hop per clock. It carries a running count of queue slots already claimed. Each station keeps its outgoing messages in a local FIFO. When the token reaches a station, the station claims slots for the messages it holds at that moment. It adds that number to the token and passes the token on. The value it received is the first slot offset it owns, and it hands that offset to the writer that drains the FIFO.

The station built with `IS_HEAD = 1` opens each superstep. It launches a token whose value is its own claim starting from zero. It then absorbs the token when the token comes back around the ring. The returned value is the size of the next queue, and a zero value tells the system that no work remains. The writer may pop only messages whose slots have been claimed.

State machine (`tr_pkg::ring_state_e`):
- `ST_RELAY` is the only state of a non-head station. It has a self-loop.
- The head station has three states:
  - `ST_IDLE` moves to `ST_WAIT` on `step_start` (launch).
  - `ST_WAIT` moves to `ST_REPORT` on a valid returning token (absorb).
  - `ST_REPORT` moves back to `ST_IDLE` unconditionally (report).

Top module: `tr_slot_reserve`

## Requirements
- R1: After reset, `tok_out_vld`, `rsv_valid`, `step_done` and `wr_avail` are 0, and `msg_ready` is 1.
- R2: In a non-head station, a valid token with value V in cycle t appears on `tok_out_*` in cycle t+1 with value V+P, where P is the number of unclaimed buffered messages. When P>0, `rsv_valid` pulses in cycle t+1 with `rsv_base`=V and `rsv_count`=P.
- R3: A cycle with `tok_in_vld`=0 claims nothing and produces `tok_out_vld`=0 in the next cycle.
- R4: Only messages already stored before the token's clock edge are claimed. A message pushed in the same cycle as the token arrives waits for the next token.
- R5: `wr_avail` is 1 exactly while claimed but unpopped messages exist. `wr_pop` while `wr_avail`=0 removes nothing. Messages leave in push order on `wr_data`.
- R6: With `DEPTH` messages stored, `msg_ready` is 0 and a push is dropped.
- R7: A head station in `ST_IDLE` that sees `step_start` emits a valid token in the next cycle. The token value is its unclaimed count P, with `rsv_base`=0 and `rsv_count`=P.
- R8: A head station in `ST_WAIT` that receives a valid token with value V raises `step_done` for exactly one cycle in the next cycle. At the same time `step_total`=V and `step_halt`=(V==0), and the token is not forwarded.
- R9: A head station ignores `tok_in_vld` outside `ST_WAIT` and ignores `step_start` outside `ST_IDLE`.
- R10: With nothing unclaimed, a token passes with its value unchanged and `rsv_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_in_vld | input | 1 | Token from previous station is valid |
| tok_in_val | input | TOK_W | Token value from previous station |
| tok_out_vld | output | 1 | Token to next station is valid |
| tok_out_val | output | TOK_W | Token value to next station |
| msg_push | input | 1 | Producer offers a message |
| msg_data | input | MSG_W | Message word |
| msg_ready | output | 1 | FIFO can accept a message |
| wr_avail | output | 1 | A claimed message is ready for the writer |
| wr_pop | input | 1 | Writer takes the head message |
| wr_data | output | MSG_W | Head message of the FIFO |
| rsv_valid | output | 1 | A claim was made this cycle |
| rsv_base | output | TOK_W | First queue slot of the claim |
| rsv_count | output | $clog2(DEPTH+1) | Number of slots claimed |
| step_start | input | 1 | Head only: open a superstep |
| step_done | output | 1 | Head only: token has returned |
| step_total | output | TOK_W | Head only: messages in next queue |
| step_halt | output | 1 | Head only: total was zero |

## Verification
The bench claims slots with different backlog sizes and with an empty backlog. It checks the forwarded value and the offset returned to the writer each time. A design that adds after forwarding, or reports the new value as the base, gives every writer overlapping slots. One message is pushed in the very cycle the token arrives. A design that counts it would claim a slot that the next station's offset also covers.

The bench also tries a pop with no claim, fills the FIFO to capacity, and offers one more word. A leaky design would release unclaimed messages, or overwrite the oldest entry. On the head station, the bench sends a stray token while idle and a second start while waiting. A design that acts on either would report a total early or launch two tokens in one superstep.

// File: rtl/tr_pkg.sv
package tr_pkg;
    typedef enum logic [1:0] {
        ST_RELAY  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPORT = 2'd3
    } ring_state_e;
endpackage

// File: rtl/tr_msg_fifo.sv
module tr_msg_fifo #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tr_ring_ctl.sv
module tr_ring_ctl
    import tr_pkg::*;
#(
    parameter bit IS_HEAD = 1'b0,
    parameter int TOK_W   = 16,
    parameter int CW      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_in_vld,
    input  logic [TOK_W-1:0] tok_in_val,
    input  logic             step_start,
    input  logic [CW-1:0]    fifo_count,
    input  logic             wr_pop,
    output logic             tok_out_vld,
    output logic [TOK_W-1:0] tok_out_val,
    output logic             rsv_valid,
    output logic [TOK_W-1:0] rsv_base,
    output logic [CW-1:0]    rsv_count,
    output logic             step_done,
    output logic [TOK_W-1:0] step_total,
    output logic             step_halt,
    output logic             wr_avail,
    output logic             pop_fire
);
    localparam ring_state_e RST_ST = IS_HEAD ? ST_IDLE : ST_RELAY;

    ring_state_e      state, state_nx;
    logic [CW-1:0]    credit;
    logic [CW-1:0]    unclaimed;
    logic             take, absorb;
    logic [TOK_W-1:0] take_base;

    assign unclaimed = fifo_count - credit;
    assign wr_avail  = (credit != '0);
    assign pop_fire  = wr_pop && wr_avail;
    assign take      = ((state == ST_RELAY) && tok_in_vld) ||
                       ((state == ST_IDLE) && step_start);
    assign absorb    = (state == ST_WAIT) && tok_in_vld;
    assign take_base = (state == ST_IDLE) ? '0 : tok_in_val;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RST_ST;
        else        state <= state_nx;
    end

    // transitions: launch, absorb, report
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RELAY:  state_nx = ST_RELAY;
            ST_IDLE:   if (step_start) state_nx = ST_WAIT;
            ST_WAIT:   if (tok_in_vld) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = RST_ST;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_out_vld <= 1'b0;
            tok_out_val <= '0;
            rsv_valid   <= 1'b0;
            rsv_base    <= '0;
            rsv_count   <= '0;
            step_done   <= 1'b0;
            step_total  <= '0;
            step_halt   <= 1'b0;
            credit      <= '0;
        end else begin
            tok_out_vld <= take;
            rsv_valid   <= take && (unclaimed != '0);
            step_done   <= absorb;
            if (take) begin
                tok_out_val <= take_base + TOK_W'(unclaimed);
                rsv_base    <= take_base;
                rsv_count   <= unclaimed;
            end
            if (absorb) begin
                step_total <= tok_in_val;
                step_halt  <= (tok_in_val == '0);
            end
            credit <= credit + (take ? unclaimed : '0) - (pop_fire ? CW'(1) : '0);
        end
    end
endmodule

// File: rtl/tr_slot_reserve.sv
module tr_slot_reserve #(
    parameter bit IS_HEAD = 1'b0,
    parameter int DEPTH   = 512,
    parameter int MSG_W   = 32,
    parameter int TOK_W   = 16,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_in_vld,
    input  logic [TOK_W-1:0] tok_in_val,
    output logic             tok_out_vld,
    output logic [TOK_W-1:0] tok_out_val,
    input  logic             msg_push,
    input  logic [MSG_W-1:0] msg_data,
    output logic             msg_ready,
    output logic             wr_avail,
    input  logic             wr_pop,
    output logic [MSG_W-1:0] wr_data,
    output logic             rsv_valid,
    output logic [TOK_W-1:0] rsv_base,
    output logic [CW-1:0]    rsv_count,
    input  logic             step_start,
    output logic             step_done,
    output logic [TOK_W-1:0] step_total,
    output logic             step_halt
);
    logic [CW-1:0] fifo_count;
    logic          fifo_full;
    logic          pop_fire;

    assign msg_ready = !fifo_full;

    tr_msg_fifo #(.DEPTH(DEPTH), .DW(MSG_W), .CW(CW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (msg_push),
        .din   (msg_data),
        .pop   (pop_fire),
        .dout  (wr_data),
        .count (fifo_count),
        .full  (fifo_full)
    );

    tr_ring_ctl #(.IS_HEAD(IS_HEAD), .TOK_W(TOK_W), .CW(CW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_in_vld  (tok_in_vld),
        .tok_in_val  (tok_in_val),
        .step_start  (step_start),
        .fifo_count  (fifo_count),
        .wr_pop      (wr_pop),
        .tok_out_vld (tok_out_vld),
        .tok_out_val (tok_out_val),
        .rsv_valid   (rsv_valid),
        .rsv_base    (rsv_base),
        .rsv_count   (rsv_count),
        .step_done   (step_done),
        .step_total  (step_total),
        .step_halt   (step_halt),
        .wr_avail    (wr_avail),
        .pop_fire    (pop_fire)
    );
endmodule

// File: rtl/tr_slot_reserve_chk.sv
module tr_slot_reserve_chk #(
    parameter bit IS_HEAD = 1'b0,
    parameter int TOK_W   = 16,
    parameter int CW      = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tok_in_vld,
    input logic             tok_out_vld,
    input logic [TOK_W-1:0] tok_out_val,
    input logic             msg_push,
    input logic             msg_ready,
    input logic             wr_avail,
    input logic             wr_pop,
    input logic             rsv_valid,
    input logic [TOK_W-1:0] rsv_base,
    input logic [CW-1:0]    rsv_count,
    input logic             step_done
);
    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && tok_out_vld) |-> (tok_out_val == rsv_base + TOK_W'(rsv_count)));

    p_claim_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid |-> wr_avail);

    p_stay_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_ready && !wr_pop) |=> !msg_ready);

    if (IS_HEAD) begin : g_head
        p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            step_done |=> !step_done);
        p_absorb_r8: assert property (@(posedge clk) disable iff (!rst_n)
            step_done |-> !tok_out_vld);
    end else begin : g_relay
        p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tok_in_vld |=> tok_out_vld);
        p_idle_token_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !tok_in_vld |=> (!tok_out_vld && !rsv_valid));
        p_no_head_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !step_done);
    end

    // msg_push is an input of interest for R6; tie it into a trivial use-free check
    p_push_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_push && !msg_ready && !wr_pop) |=> !msg_ready);
endmodule

bind tr_slot_reserve tr_slot_reserve_chk #(.IS_HEAD(IS_HEAD), .TOK_W(TOK_W), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_in_vld  (tok_in_vld),
    .tok_out_vld (tok_out_vld),
    .tok_out_val (tok_out_val),
    .msg_push    (msg_push),
    .msg_ready   (msg_ready),
    .wr_avail    (wr_avail),
    .wr_pop      (wr_pop),
    .rsv_valid   (rsv_valid),
    .rsv_base    (rsv_base),
    .rsv_count   (rsv_count),
    .step_done   (step_done)
);

// File: tb/sim_tr_slot_reserve.sv
`timescale 1ns/1ps
module sim_tr_slot_reserve;
    localparam int DEPTH = 512;
    localparam int MSG_W = 32;
    localparam int TOK_W = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    // {pushes, token in, expected token out, expected claim}
    localparam int NV = 5;
    localparam int VEC [NV][4] = '{
        '{3,   0,   3, 3},
        '{0,   7,   7, 0},
        '{5, 100, 105, 5},
        '{1, 200, 201, 1},
        '{8,  40,  48, 8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int push_seq = 0;
    int pop_seq  = 0;

    // relay station u0
    logic             a_tin_v = 0, a_tout_v, a_push = 0, a_ready, a_avail, a_pop = 0;
    logic             a_rv, a_start = 0, a_done, a_halt;
    logic [TOK_W-1:0] a_tin = '0, a_tout, a_base, a_total;
    logic [MSG_W-1:0] a_din = '0, a_dout;
    logic [CW-1:0]    a_cnt;

    // head station u1
    logic             b_tin_v = 0, b_tout_v, b_push = 0, b_ready, b_avail, b_pop = 0;
    logic             b_rv, b_start = 0, b_done, b_halt;
    logic [TOK_W-1:0] b_tin = '0, b_tout, b_base, b_total;
    logic [MSG_W-1:0] b_din = '0, b_dout;
    logic [CW-1:0]    b_cnt;

    tr_slot_reserve #(.IS_HEAD(1'b0), .DEPTH(DEPTH), .MSG_W(MSG_W), .TOK_W(TOK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_in_vld(a_tin_v), .tok_in_val(a_tin),
        .tok_out_vld(a_tout_v), .tok_out_val(a_tout), .msg_push(a_push), .msg_data(a_din),
        .msg_ready(a_ready), .wr_avail(a_avail), .wr_pop(a_pop), .wr_data(a_dout),
        .rsv_valid(a_rv), .rsv_base(a_base), .rsv_count(a_cnt), .step_start(a_start),
        .step_done(a_done), .step_total(a_total), .step_halt(a_halt));

    tr_slot_reserve #(.IS_HEAD(1'b1), .DEPTH(DEPTH), .MSG_W(MSG_W), .TOK_W(TOK_W)) u1 (
        .clk(clk), .rst_n(rst_n), .tok_in_vld(b_tin_v), .tok_in_val(b_tin),
        .tok_out_vld(b_tout_v), .tok_out_val(b_tout), .msg_push(b_push), .msg_data(b_din),
        .msg_ready(b_ready), .wr_avail(b_avail), .wr_pop(b_pop), .wr_data(b_dout),
        .rsv_valid(b_rv), .rsv_base(b_base), .rsv_count(b_cnt), .step_start(b_start),
        .step_done(b_done), .step_total(b_total), .step_halt(b_halt));

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_a(input int n);
        for (int i = 0; i < n; i++) begin
            a_push = 1'b1; a_din = MSG_W'(push_seq); push_seq++;
            tick();
        end
        a_push = 1'b0;
    endtask

    task automatic token_a(input int v);
        a_tin_v = 1'b1; a_tin = TOK_W'(v);
        tick();
        a_tin_v = 1'b0;
    endtask

    // drains n claimed messages, returns number of order/availability errors
    task automatic drain_a(input int n, output int errs);
        errs = 0;
        for (int i = 0; i < n; i++) begin
            if (!a_avail || a_dout != MSG_W'(pop_seq)) errs++;
            pop_seq++;
            a_pop = 1'b1; tick(); a_pop = 1'b0;
        end
    endtask

    task automatic drain_b(input int n, output int errs);
        errs = 0;
        for (int i = 0; i < n; i++) begin
            if (!b_avail || b_dout != MSG_W'(1000 + i)) errs++;
            b_pop = 1'b1; tick(); b_pop = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int e;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1", "u0 tok_out_vld", a_tout_v, 0);
        chk("R1", "u0 rsv_valid", a_rv, 0);
        chk("R1", "u0 wr_avail", a_avail, 0);
        chk("R1", "u0 msg_ready", a_ready, 1);
        chk("R1", "u1 step_done", b_done, 0);
        chk("R1", "u1 tok_out_vld", b_tout_v, 0);

        // vector table: R2 relay sums, R10 empty backlog
        for (int v = 0; v < NV; v++) begin
            push_a(VEC[v][0]);
            token_a(VEC[v][1]);
            chk("R2", "tok_out_vld", a_tout_v, 1);
            chk("R2", "tok_out_val", int'(a_tout), VEC[v][2]);
            chk(VEC[v][3] == 0 ? "R10" : "R2", "rsv_valid", a_rv, VEC[v][3] != 0);
            if (VEC[v][3] != 0) begin
                chk("R2", "rsv_base", int'(a_base), VEC[v][1]);
                chk("R2", "rsv_count", int'(a_cnt), VEC[v][3]);
            end
            drain_a(VEC[v][3], e);
            chk("R5", "drain errors", e, 0);
            chk("R5", "wr_avail after drain", a_avail, 0);
        end

        // R3: no valid token, nothing claimed
        push_a(2);
        repeat (3) tick();
        chk("R3", "tok_out_vld idle", a_tout_v, 0);
        chk("R3", "wr_avail idle", a_avail, 0);
        token_a(10);
        chk("R3", "claim after idle", int'(a_tout), 12);
        drain_a(2, e);
        chk("R3", "drain errors", e, 0);

        // R4: push in same cycle as token
        push_a(2);
        a_push = 1'b1; a_din = MSG_W'(push_seq); push_seq++;
        a_tin_v = 1'b1; a_tin = TOK_W'(0);
        tick();
        a_push = 1'b0; a_tin_v = 1'b0;
        chk("R4", "rsv_count snapshot", int'(a_cnt), 2);
        chk("R4", "tok_out_val snapshot", int'(a_tout), 2);
        token_a(50);
        chk("R4", "late message claimed next pass", int'(a_cnt), 1);
        chk("R4", "late base", int'(a_base), 50);
        drain_a(3, e);
        chk("R4", "drain errors", e, 0);

        // R5: pop without claim has no effect
        push_a(1);
        a_pop = 1'b1; tick(); a_pop = 1'b0;
        chk("R5", "wr_avail unclaimed", a_avail, 0);
        token_a(0);
        chk("R5", "message kept after early pop", int'(a_cnt), 1);
        drain_a(1, e);
        chk("R5", "drain errors", e, 0);

        // R6: full FIFO
        push_a(DEPTH);
        chk("R6", "msg_ready full", a_ready, 0);
        a_push = 1'b1; a_din = 32'hDEAD_BEEF; tick(); a_push = 1'b0;
        token_a(0);
        chk("R6", "claim at capacity", int'(a_cnt), DEPTH);
        drain_a(DEPTH, e);
        chk("R6", "order after overflow attempt", e, 0);
        chk("R6", "empty after drain", a_avail, 0);
        chk("R6", "msg_ready after drain", a_ready, 1);

        // R9: head ignores token while idle
        b_tin_v = 1'b1; b_tin = TOK_W'(33); tick(); b_tin_v = 1'b0;
        chk("R9", "idle token not forwarded", b_tout_v, 0);
        chk("R9", "idle token no done", b_done, 0);

        // R7: launch with backlog of 4
        for (int i = 0; i < 4; i++) begin
            b_push = 1'b1; b_din = MSG_W'(1000 + i); tick();
        end
        b_push = 1'b0;
        b_start = 1'b1; tick(); b_start = 1'b0;
        chk("R7", "launch valid", b_tout_v, 1);
        chk("R7", "launch value", int'(b_tout), 4);
        chk("R7", "launch base", int'(b_base), 0);
        chk("R7", "launch count", int'(b_cnt), 4);

        // R9: second start while waiting
        b_start = 1'b1; tick(); b_start = 1'b0;
        chk("R9", "no relaunch in wait", b_tout_v, 0);

        // R8: token returns
        b_tin_v = 1'b1; b_tin = TOK_W'(9); tick(); b_tin_v = 1'b0;
        chk("R8", "step_done", b_done, 1);
        chk("R8", "step_total", int'(b_total), 9);
        chk("R8", "step_halt", b_halt, 0);
        chk("R8", "token absorbed", b_tout_v, 0);
        tick();
        chk("R8", "done one cycle", b_done, 0);
        drain_b(4, e);
        chk("R5", "head drain errors", e, 0);

        // R10 + R8: empty superstep ends execution
        b_start = 1'b1; tick(); b_start = 1'b0;
        chk("R10", "head empty launch value", int'(b_tout), 0);
        chk("R10", "head empty no claim", b_rv, 0);
        b_tin_v = 1'b1; b_tin = TOK_W'(0); tick(); b_tin_v = 1'b0;
        chk("R8", "halt on zero", b_halt, 1);
        chk("R8", "zero total done", b_done, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule